// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Register Block

This block is the shared control and interrupt register file of a four-channel pulse-width modulation peripheral, sitting on a simple memory-mapped register bus. Software turns channels on and off through a pair of write-one strobe locations, one that sets and one that clears, and reads the resulting enable state back through a read-only status location. Interrupt masks work the same way: a set location, a clear location and a read-back location.

The waveform generators live outside the block and tell it when each of their periods ends by pulsing one input per channel. An enabled channel that ends a period latches a pending bit. Reading the interrupt status location returns the pending bits and clears them in the same access. A single interrupt line goes high whenever a pending bit is unmasked. The block also decodes each channel's own register window and passes accesses in that range to the matching generator, muxing the generator's read data back onto the bus.

Top module: `pwm_chan_ctl`

## Requirements
- R1: After reset every enable, mask and pending bit is zero, the mode word is zero, `irq` is low and `bus_rdata` is zero.
- R2: A write to offset 0x04 sets channel n's enable for each 1 in bit n, a write to offset 0x08 clears it for each 1 in bit n, and 0 bits leave their channels alone; `chan_en` shows the state and a read of offset 0x0C returns it in bits 3:0.
- R3: A write to offset 0x10 sets mask bit n for each 1 in bit n, a write to offset 0x14 clears it, 0 bits change nothing, and a read of offset 0x18 returns the mask in bits 3:0.
- R4: A one-cycle pulse on `period_end[n]` sets pending bit n when channel n is enabled in that cycle; a pulse on a disabled channel sets nothing.
- R5: A read of offset 0x1C returns the pending bits in bits 3:0 and clears them; all read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R6: A period-end pulse on an enabled channel in the same cycle as a read of offset 0x1C leaves that channel's bit pending after the read (the read itself returns the bits pending before that cycle).
- R7: `irq` is high exactly when some channel has both its pending bit and its mask bit set.
- R8: Written bits 31:4 of offsets 0x04, 0x08, 0x10 and 0x14 have no effect, and reads of 0x0C, 0x18 and 0x1C return 0 in bits 31:4.
- R9: Offset 0x00 holds a 32-bit mode word that reads back what was last written.
- R10: An access at 0x200 + n*0x20 + k (k below 0x20, n below 4) drives only `chan_sel[n]`, with `chan_off` = k and `chan_wr`/`chan_rd` following the access; a read there returns word n of `chan_rdata`; an address matching no location (such as 0x280 or 0x020) selects no channel and reads 0.
- R11: Writes to offsets 0x0C, 0x18 and 0x1C change no enable, mask or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| chan_sel | output | 4 | One-hot select of the channel window being accessed |
| chan_wr | output | 1 | Write into a channel window |
| chan_rd | output | 1 | Read from a channel window |
| chan_off | output | 5 | Byte offset inside the selected window |
| chan_wdata | output | 32 | Write data toward the channel registers |
| chan_rdata | input | 128 | Read data of every channel window, channel n in bits 32n+31:32n |
| period_end | input | 4 | Period-end pulse from each waveform generator |
| chan_en | output | 4 | Per-channel enable state |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: four channels, a 12-bit address, windows of 0x20 bytes from 0x200, so the last window ends at 0x27F and 0x280 is the first address past it, which the bench probes. With only four channels every combination of enable, mask and pending bits is reachable by the random mix of strobe writes, status reads and period-end pulses, including pulses that coincide with an acknowledging read or with an enable change in the same cycle. Directed steps cover high-bit writes, writes to read-only offsets and the read-versus-event race.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;

  // Decoded target of one bus access.
  typedef enum logic [3:0] {
    RS_NONE,
    RS_MODE,
    RS_ENA_SET,
    RS_ENA_CLR,
    RS_ENA_STAT,
    RS_MSK_SET,
    RS_MSK_CLR,
    RS_MSK_STAT,
    RS_PND_STAT,
    RS_WIN
  } reg_sel_e;

  // Global register byte offsets; software depends on these.
  localparam logic [4:0] OFF_MODE     = 5'h00;
  localparam logic [4:0] OFF_ENA_SET  = 5'h04;
  localparam logic [4:0] OFF_ENA_CLR  = 5'h08;
  localparam logic [4:0] OFF_ENA_STAT = 5'h0C;
  localparam logic [4:0] OFF_MSK_SET  = 5'h10;
  localparam logic [4:0] OFF_MSK_CLR  = 5'h14;
  localparam logic [4:0] OFF_MSK_STAT = 5'h18;
  localparam logic [4:0] OFF_PND_STAT = 5'h1C;

  // Map a low offset inside the global block to its register.
  function automatic reg_sel_e glob_decode(input logic [4:0] off);
    case (off)
      OFF_MODE:     return RS_MODE;
      OFF_ENA_SET:  return RS_ENA_SET;
      OFF_ENA_CLR:  return RS_ENA_CLR;
      OFF_ENA_STAT: return RS_ENA_STAT;
      OFF_MSK_SET:  return RS_MSK_SET;
      OFF_MSK_CLR:  return RS_MSK_CLR;
      OFF_MSK_STAT: return RS_MSK_STAT;
      OFF_PND_STAT: return RS_PND_STAT;
      default:      return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
  import pwm_ctl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NCH        = 4,
  parameter int WIN_BASE   = 'h200,
  parameter int WIN_STRIDE = 'h20,
  localparam int IDX_W     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OFF_W     = $clog2(WIN_STRIDE)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              access,
  output reg_sel_e          sel,
  output logic              win_hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic [OFF_W-1:0]  win_off,
  output logic [NCH-1:0]    chan_sel
);

  localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(NCH * WIN_STRIDE);
  localparam logic [ADDR_W-1:0] GLB_SPAN = ADDR_W'(32);

  logic [ADDR_W-1:0] win_rel;
  logic              glb_hit;

  // Distance from the first window; every bit feeds the range check.
  function automatic logic rel_in_span(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] rel);
    return (a >= WIN_LO) && (rel < WIN_SPAN);
  endfunction

  assign win_rel = addr - WIN_LO;
  assign win_hit = rel_in_span(addr, win_rel);
  assign glb_hit = (addr < GLB_SPAN);
  assign win_idx = win_rel[OFF_W +: IDX_W];
  assign win_off = win_rel[OFF_W-1:0];

  always_comb begin
    if (glb_hit)      sel = glob_decode(addr[4:0]);
    else if (win_hit) sel = RS_WIN;
    else              sel = RS_NONE;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign chan_sel[g] = access && win_hit && (win_idx == IDX_W'(g));
  end

endmodule

// File: rtl/pwm_chan_flags.sv
module pwm_chan_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic im_set,
  input  logic im_clr,
  input  logic ack,
  input  logic evt,
  output logic en,
  output logic msk,
  output logic pend,
  output logic evt_taken
);

  // Event counts only while the channel is on in that cycle.
  assign evt_taken = evt && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      msk  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (en_set)      en <= 1'b1;
      else if (en_clr) en <= 1'b0;
      if (im_set)      msk <= 1'b1;
      else if (im_clr) msk <= 1'b0;
      // A new event wins over the acknowledge so it is never dropped.
      if (evt_taken)   pend <= 1'b1;
      else if (ack)    pend <= 1'b0;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set) |=> !en); // R2
  AST_MSK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    im_set |=> msk); // R3
  AST_MSK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (im_clr && !im_set) |=> !msk); // R3
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && en) |=> pend); // R6
  AST_EVT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !en) |=> !pend); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt_taken) |=> !pend); // R5

endmodule

// File: rtl/pwm_rd_mux.sv
module pwm_rd_mux
  import pwm_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCH    = 4,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  reg_sel_e              sel,
  input  logic [IDX_W-1:0]      win_idx,
  input  logic [DATA_W-1:0]     mode_q,
  input  logic [NCH-1:0]        en_vec,
  input  logic [NCH-1:0]        msk_vec,
  input  logic [NCH-1:0]        pnd_vec,
  input  logic [NCH*DATA_W-1:0] chan_rdata,
  output logic [DATA_W-1:0]     rd_next
);

  // Zero-extend a per-channel vector to a bus word.
  function automatic logic [DATA_W-1:0] widen(input logic [NCH-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NCH-1:0] = v;
    return w;
  endfunction

  always_comb begin
    case (sel)
      RS_MODE:     rd_next = mode_q;
      RS_ENA_STAT: rd_next = widen(en_vec);
      RS_MSK_STAT: rd_next = widen(msk_vec);
      RS_PND_STAT: rd_next = widen(pnd_vec);
      RS_WIN:      rd_next = chan_rdata[win_idx*DATA_W +: DATA_W];
      default:     rd_next = '0;
    endcase
  end

endmodule

// File: rtl/pwm_chan_ctl.sv
module pwm_chan_ctl
  import pwm_ctl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int NCH        = 4,
  parameter int WIN_BASE   = 'h200,
  parameter int WIN_STRIDE = 'h20,
  localparam int OFF_W     = $clog2(WIN_STRIDE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NCH-1:0]        chan_sel,
  output logic                  chan_wr,
  output logic                  chan_rd,
  output logic [OFF_W-1:0]      chan_off,
  output logic [DATA_W-1:0]     chan_wdata,
  input  logic [NCH*DATA_W-1:0] chan_rdata,
  input  logic [NCH-1:0]        period_end,
  output logic [NCH-1:0]        chan_en,
  output logic                  irq
);

  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  reg_sel_e           sel;
  logic               win_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [DATA_W-1:0]  mode_q;
  logic [DATA_W-1:0]  rd_next;
  logic [NCH-1:0]     en_vec, msk_vec, pnd_vec, evt_taken;
  logic [NCH-1:0]     wr_en_set, wr_en_clr, wr_im_set, wr_im_clr;
  logic               ack_pend;

  pwm_addr_dec #(
    .ADDR_W(ADDR_W), .NCH(NCH), .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE)
  ) u_dec (
    .addr     (bus_addr),
    .access   (bus_wr | bus_rd),
    .sel      (sel),
    .win_hit  (win_hit),
    .win_idx  (win_idx),
    .win_off  (chan_off),
    .chan_sel (chan_sel)
  );

  // Write-one strobes: only the low NCH data bits reach the channels.
  function automatic logic [NCH-1:0] strobe(input logic hit,
                                            input logic [DATA_W-1:0] d);
    return hit ? d[NCH-1:0] : '0;
  endfunction

  assign wr_en_set = strobe(bus_wr && (sel == RS_ENA_SET), bus_wdata);
  assign wr_en_clr = strobe(bus_wr && (sel == RS_ENA_CLR), bus_wdata);
  assign wr_im_set = strobe(bus_wr && (sel == RS_MSK_SET), bus_wdata);
  assign wr_im_clr = strobe(bus_wr && (sel == RS_MSK_CLR), bus_wdata);
  assign ack_pend  = bus_rd && (sel == RS_PND_STAT);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_set    (wr_en_set[g]),
      .en_clr    (wr_en_clr[g]),
      .im_set    (wr_im_set[g]),
      .im_clr    (wr_im_clr[g]),
      .ack       (ack_pend),
      .evt       (period_end[g]),
      .en        (en_vec[g]),
      .msk       (msk_vec[g]),
      .pend      (pnd_vec[g]),
      .evt_taken (evt_taken[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (bus_wr && (sel == RS_MODE)) mode_q <= bus_wdata;
  end

  pwm_rd_mux #(.DATA_W(DATA_W), .NCH(NCH)) u_mux (
    .sel        (sel),
    .win_idx    (win_idx),
    .mode_q     (mode_q),
    .en_vec     (en_vec),
    .msk_vec    (msk_vec),
    .pnd_vec    (pnd_vec),
    .chan_rdata (chan_rdata),
    .rd_next    (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign chan_wr    = bus_wr && win_hit;
  assign chan_rd    = bus_rd && win_hit;
  assign chan_wdata = bus_wdata;
  assign chan_en    = en_vec;
  assign irq        = |(pnd_vec & msk_vec);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel)); // R10
  AST_SEL_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != '0) |-> (chan_wr || chan_rd)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == RS_NONE) |=> (bus_rdata == '0)); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk_vec != '0)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R5
  AST_EVT_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_taken & ~en_vec) == '0); // R4

endmodule

// File: tb/tb_pwm_chan_ctl.sv
module tb_pwm_chan_ctl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [3:0]   chan_sel;
  logic         chan_wr, chan_rd;
  logic [4:0]   chan_off;
  logic [31:0]  chan_wdata;
  logic [127:0] chan_rdata;
  logic [3:0]   period_end = '0;
  logic [3:0]   chan_en;
  logic         irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // Model state
  logic [31:0] m_mode = '0;
  logic [3:0]  m_en = '0, m_msk = '0, m_pnd = '0;

  always #2 clk = ~clk;

  for (genvar n = 0; n < 4; n++) begin : g_crd
    assign chan_rdata[n*32 +: 32] = 32'h5A00_0000 | (n << 4);
  end

  pwm_chan_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_sel(chan_sel), .chan_wr(chan_wr), .chan_rd(chan_rd),
    .chan_off(chan_off), .chan_wdata(chan_wdata), .chan_rdata(chan_rdata),
    .period_end(period_end), .chan_en(chan_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [11:0] a);
    return (a >= 12'h200) && (a < 12'h280);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (in_win(a)) return 32'h5A00_0000 | (32'((a - 12'h200) >> 5) << 4);
    case (a)
      12'h000: return m_mode;
      12'h00C: return {28'b0, m_en};
      12'h018: return {28'b0, m_msk};
      12'h01C: return {28'b0, m_pnd};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    if (in_win(a)) return "R10 window read";
    case (a)
      12'h000: return "R9 mode read";
      12'h00C: return "R2 enable status read";
      12'h018: return "R3 mask read";
      12'h01C: return "R5 pending read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  // One bus cycle; called at a falling edge, returns at the next one.
  task automatic step(input bit w, input bit r, input logic [11:0] a,
                      input logic [31:0] d, input logic [3:0] pe);
    logic [31:0] rexp;
    logic [3:0]  sel_exp;
    logic [3:0]  en_old;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; period_end = pe;
    #1;
    sel_exp = ((w || r) && in_win(a)) ? 4'(1 << ((a - 12'h200) >> 5)) : 4'b0;
    if (w || r) begin
      chk("R10 chan_sel", {28'b0, chan_sel}, {28'b0, sel_exp});
      if (in_win(a)) begin
        chk("R10 chan_off", {27'b0, chan_off}, {27'b0, a[4:0]});
        chk("R10 chan_wr/rd", {30'b0, chan_wr, chan_rd}, {30'b0, w, r});
      end
    end
    rexp = exp_read(a);
    @(posedge clk);
    en_old = m_en;
    if (w) begin
      case (a)
        12'h000: m_mode = d;
        12'h004: m_en  = m_en | d[3:0];
        12'h008: m_en  = m_en & ~d[3:0];
        12'h010: m_msk = m_msk | d[3:0];
        12'h014: m_msk = m_msk & ~d[3:0];
        default: ;
      endcase
    end
    if (r && a == 12'h01C) m_pnd = 4'b0;
    m_pnd = m_pnd | (pe & en_old);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; period_end = '0;
    if (r) chk(rd_tag(a), bus_rdata, rexp);
    chk("R2 chan_en", {28'b0, chan_en}, {28'b0, m_en});
    chk("R7 irq", {31'b0, irq}, {31'b0, |(m_pnd & m_msk)});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 0, a, d, 4'b0);
  endtask

  task automatic rd(input logic [11:0] a);
    step(0, 1, a, 32'b0, 4'b0);
  endtask

  initial begin
    #800_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [11:0] ADDRS [12] = '{12'h000, 12'h004, 12'h008, 12'h00C,
    12'h010, 12'h014, 12'h018, 12'h01C, 12'h200, 12'h27C, 12'h280, 12'h020};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bus_rdata", bus_rdata, 32'b0);
    chk("R1 irq", {31'b0, irq}, 32'b0);
    chk("R1 chan_en", {28'b0, chan_en}, 32'b0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h00C); rd(12'h018); rd(12'h01C); rd(12'h000);

    // R9 mode word
    wr(12'h000, 32'hDEAD_BEEF); rd(12'h000);
    // R8 high bits ignored
    wr(12'h004, 32'hFFFF_FFF0); rd(12'h00C);
    wr(12'h010, 32'hFFFF_FFF0); rd(12'h018);
    // R2 set and clear
    wr(12'h004, 32'h0000_0005); rd(12'h00C);
    wr(12'h004, 32'h0000_0002); rd(12'h00C);
    wr(12'h008, 32'h0000_0004); rd(12'h00C);
    wr(12'h008, 32'hFFFF_FFF0); rd(12'h00C);
    // R4: channel 2 disabled, channel 0 enabled
    step(0, 0, 12'h000, 32'b0, 4'b0101); rd(12'h01C); rd(12'h01C);
    // R7: pending unmasked then masked
    step(0, 0, 12'h000, 32'b0, 4'b0010);
    wr(12'h010, 32'h0000_0002);
    wr(12'h014, 32'h0000_0002);
    wr(12'h010, 32'h0000_0003);
    // R11 writes to read-only offsets
    wr(12'h00C, 32'h0000_000F); wr(12'h018, 32'h0000_000F); wr(12'h01C, 32'h0000_000F);
    rd(12'h00C); rd(12'h018);
    // R6 event during acknowledging read
    step(0, 1, 12'h01C, 32'b0, 4'b0001); rd(12'h01C); rd(12'h01C);
    // R10 windows and unmapped
    for (int n = 0; n < 4; n++) begin
      rd(12'h200 + 12'(n * 32) + 12'h4);
      step(1, 0, 12'h200 + 12'(n * 32) + 12'h1F, 32'h1234_5678, 4'b0);
    end
    rd(12'h280); rd(12'h020); rd(12'h002); wr(12'h280, 32'hF);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [11:0] a;
      logic [3:0]  pe;
      k  = $urandom % 10;
      a  = ADDRS[$urandom % 12];
      pe = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0;
      if (k < 4)      step(1, 0, a, $urandom, pe);
      else if (k < 8) step(0, 1, ($urandom % 2) ? 12'h01C : a, 32'b0, pe);
      else            step(0, 0, 12'h000, 32'b0, pe);
    end
    rd(12'h00C); rd(12'h018); rd(12'h01C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule